// File: doc/BRIEF.md
# Real-Time-Clock Indexed Register File

This block holds the 128 bytes of configuration and clock storage that sit beside a real-time clock, and it owns the four control registers that govern that clock. A host reaches it through a narrow byte port with two addresses. The even address selects a 7-bit index. The odd address then reads or writes the byte at that index. Control registers A to D have their own access rules. One status bit cannot be written by the bus. The flag register empties itself when read and releases the interrupt line. Two registers ignore bus writes.

A second, host-side port writes bytes directly, with no index step. When such a write lands in the configuration range 0x10 to 0x2D, a sequential engine sums that range again into a 16-bit checksum. The checksum is presented at indices 0x2E (high byte) and 0x2F (low byte). The calendar counter and the periodic-rate generator are separate blocks. They see every bus write to the time-of-day bytes and to registers A and B as a strobe with index and data. They report back through event-flag inputs and through inputs that set and clear the update-in-progress bit.

Top module: `cmos_regfile`

## Requirements
- R1: After reset, register A (index 10) reads 0x26, B (index 11) reads 0x02, C (index 12) reads 0x00 and D (index 13) reads 0x80. The interrupt output is low, the busy output is low, and the checksum bytes read 0x00.
- R2: A bus write with bus_addr=0 latches bus_wdata[6:0] as the index. A bus read with bus_addr=0 returns 0xFF.
- R3: Bit 7 of register A (update in progress) cannot be changed by a bus write. A bus write to index 10 replaces bits 6:0 only.
- R4: Bus writes to index 12 (C), index 13 (D), index 0x2E and index 0x2F leave those bytes unchanged.
- R5: Each bit set on evt_set is ORed into register C and drives irq high. A bus read of index 12 returns C's current value. At that clock edge C clears to 0x00 and irq falls, unless new event bits arrive in the same cycle.
- R6: A bus write to register B with bit 7 high clears register A bit 7 at the same edge. This overrides uip_set.
- R7: A bus read of any index other than 10 to 13, 0x2E and 0x2F returns the byte written last through either port. When both ports write the same index in one cycle, the backdoor value wins. Backdoor writes to indices 10 to 13, 0x2E and 0x2F are ignored.
- R8: A backdoor write to an index from 0x10 to 0x2D starts a recompute. The recompute forms the 16-bit sum of bytes 0x10 to 0x2D and stores the high byte at 0x2E and the low byte at 0x2F. cksum_busy is high for the 30 cycles after the write. Reads of 0x2E and 0x2F during that time return the previous sum. A new trigger while busy restarts the sum.
- R9: Bus writes, and backdoor writes outside 0x10 to 0x2D, do not start a recompute.
- R10: A bus write with bus_addr=1 to an index from 0 to 11 pulses fwd_stb for one cycle after the write edge, with fwd_idx and fwd_data holding the index and the byte. Bus writes to other indices give no pulse.
- R11: uip_set sets register A bit 7 and uip_clr clears it. uip_clr wins when both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe (side effects at the edge) |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, combinational |
| bd_wr | input | 1 | Backdoor write strobe |
| bd_idx | input | 7 | Backdoor byte index |
| bd_wdata | input | 8 | Backdoor write data |
| evt_set | input | 8 | Event flag bits to OR into register C |
| uip_set | input | 1 | Set register A bit 7 |
| uip_clr | input | 1 | Clear register A bit 7 |
| irq | output | 1 | Interrupt request |
| cksum_busy | output | 1 | Checksum recompute running |
| ctl_a | output | 8 | Current register A |
| ctl_b | output | 8 | Current register B |
| fwd_stb | output | 1 | Forwarded write strobe |
| fwd_idx | output | 4 | Forwarded write index |
| fwd_data | output | 8 | Forwarded write data |

## Verification
The store is swept over every ordinary index with a pattern that depends on the index, so a slip in index decode or an aliased byte shows up as a miscompare. Two backdoor fills of the checksum range are then summed in the bench. The first uses a varied pattern, which exposes a missed or repeated byte. The second is all 0xFF, which exposes a lost carry into the high byte. Reads taken while the recompute runs separate the old sum from the new one. Single-byte probes cover the protected bits, the read-clear of the flag register, the SET override and the forward strobe. Each probe sits next to a twin case that must not change anything.

// File: rtl/cmos_pkg.sv
// Package: shared index map and widths for the indexed register file.
// Assumes an 8-bit data path; the index width is set at the top level.
package cmos_pkg;
    localparam int DATA_W   = 8;
    localparam int IDX_A    = 10;
    localparam int IDX_B    = 11;
    localparam int IDX_C    = 12;
    localparam int IDX_D    = 13;
    localparam int FWD_LAST = IDX_B;
    localparam logic [DATA_W-1:0] RST_A = 8'h26;
    localparam logic [DATA_W-1:0] RST_B = 8'h02;
    localparam logic [DATA_W-1:0] RST_D = 8'h80;
endpackage

// File: rtl/cmos_ctrl_regs.sv
// Module: control registers A..D and the interrupt line.
// Does: applies the bus access rules (A bit 7 protected, C/D read-only,
// C read-clear) and merges sideband event and update-in-progress inputs.
// Assumes: strobes are single-cycle and qualified by the caller.
module cmos_ctrl_regs
    import cmos_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_c,
    input  logic [DATA_W-1:0] evt_set,
    input  logic              uip_set,
    input  logic              uip_clr,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_b,
    output logic [DATA_W-1:0] reg_c,
    output logic [DATA_W-1:0] reg_d,
    output logic              irq
);
    logic uip_q;
    logic [DATA_W-2:0] a_low_q;
    logic [DATA_W-1:0] b_q, c_q;
    logic irq_q;

    // Update-in-progress bit: SET write beats clear, clear beats set.
    always_ff @(posedge clk) begin
        if (!rst_n)                          uip_q <= RST_A[DATA_W-1];
        else if (wr_b && wr_data[DATA_W-1])  uip_q <= 1'b0;
        else if (uip_clr)                    uip_q <= 1'b0;
        else if (uip_set)                    uip_q <= 1'b1;
    end

    // Writable part of register A and all of register B.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_low_q <= RST_A[DATA_W-2:0];
            b_q     <= RST_B;
        end else begin
            if (wr_a) a_low_q <= wr_data[DATA_W-2:0];
            if (wr_b) b_q     <= wr_data;
        end
    end

    // Flag register C and the interrupt: OR in events, clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q   <= '0;
            irq_q <= 1'b0;
        end else if (rd_c) begin
            c_q   <= evt_set;
            irq_q <= |evt_set;
        end else begin
            c_q   <= c_q | evt_set;
            irq_q <= irq_q | (|evt_set);
        end
    end

    assign reg_a = {uip_q, a_low_q};
    assign reg_b = b_q;
    assign reg_c = c_q;
    assign reg_d = RST_D;
    assign irq   = irq_q;

    AST_UIP_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a && !wr_b && !uip_set && !uip_clr) |=> $stable(reg_a[DATA_W-1])); // R3
    AST_SET_DROPS_UIP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && wr_data[DATA_W-1]) |=> !reg_a[DATA_W-1]); // R6
    AST_READ_CLEARS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && evt_set == '0) |=> (reg_c == '0 && !irq)); // R5
    AST_IRQ_TRACKS_C: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (reg_c != '0)); // R5
endmodule

// File: rtl/cmos_cksum.sv
// Module: sequential checksum engine over a contiguous byte range.
// Does: on start, reads one byte per cycle for LEN cycles and commits the
// 16-bit sum; the committed sum holds until the run ends. Start restarts.
// Assumes: the caller returns rd_byte for rd_off in the same cycle.
module cmos_cksum
    import cmos_pkg::*;
#(
    parameter int LEN = 30
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [DATA_W-1:0]   rd_byte,
    output logic [$clog2(LEN)-1:0] rd_off,
    output logic                busy,
    output logic [2*DATA_W-1:0] sum
);
    localparam int CNT_W = $clog2(LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LEN - 1);

    logic [CNT_W-1:0]    cnt_q;
    logic                busy_q;
    logic [2*DATA_W-1:0] acc_q, sum_q;

    // Run control and accumulation, one byte per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            acc_q  <= '0;
            sum_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            acc_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == CNT_LAST) begin
                busy_q <= 1'b0;
                sum_q  <= acc_q + {{DATA_W{1'b0}}, rd_byte};
            end else begin
                cnt_q <= cnt_q + 1'b1;
                acc_q <= acc_q + {{DATA_W{1'b0}}, rd_byte};
            end
        end
    end

    assign rd_off = cnt_q;
    assign busy   = busy_q;
    assign sum    = sum_q;

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R8
    AST_SUM_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sum_q) |-> $fell(busy_q)); // R8
endmodule

// File: rtl/cmos_regfile.sv
// Module: top of the indexed register file.
// Does: index/data byte port, the 128-byte store, backdoor writes, the
// read mux, checksum triggering and the forward strobe to neighbours.
// Assumes: bus_wr and bus_rd are never high together; bus_rd side effects
// (register C clear) take place at the clock edge while bus_rd is high.
module cmos_regfile
    import cmos_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int CK_FIRST = 16,
    parameter int CK_LAST  = 45
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic        bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        bd_wr,
    input  logic [6:0]  bd_idx,
    input  logic [7:0]  bd_wdata,
    input  logic [7:0]  evt_set,
    input  logic        uip_set,
    input  logic        uip_clr,
    output logic        irq,
    output logic        cksum_busy,
    output logic [7:0]  ctl_a,
    output logic [7:0]  ctl_b,
    output logic        fwd_stb,
    output logic [3:0]  fwd_idx,
    output logic [7:0]  fwd_data
);
    localparam int DEPTH   = 1 << IDX_W;
    localparam int CK_LEN  = CK_LAST - CK_FIRST + 1;
    localparam int CK_HIB  = CK_LAST + 1;
    localparam int CK_LOB  = CK_LAST + 2;
    localparam int OFF_W   = $clog2(CK_LEN);

    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] reg_a, reg_b, reg_c, reg_d;
    logic [2*DATA_W-1:0] ck_sum;
    logic [OFF_W-1:0]  ck_off;
    logic [DATA_W-1:0] ck_byte;
    logic              dat_wr, dat_rd, ck_start;

    // True for indices owned by the plain byte store.
    function automatic logic is_plain(input logic [IDX_W-1:0] i);
        return !((int'(i) >= IDX_A && int'(i) <= IDX_D) ||
                 int'(i) == CK_HIB || int'(i) == CK_LOB);
    endfunction

    assign dat_wr   = bus_wr && bus_addr;
    assign dat_rd   = bus_rd && bus_addr;
    assign ck_start = bd_wr && int'(bd_idx) >= CK_FIRST && int'(bd_idx) <= CK_LAST;

    // Index latch written through the even address.
    always_ff @(posedge clk) begin
        if (!rst_n)                  idx_q <= '0;
        else if (bus_wr && !bus_addr) idx_q <= bus_wdata[IDX_W-1:0];
    end

    // Byte store: bus write first, backdoor overrides on the same index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else begin
            if (dat_wr && is_plain(idx_q))        mem[idx_q]  <= bus_wdata;
            if (bd_wr && is_plain(bd_idx))        mem[bd_idx] <= bd_wdata;
        end
    end

    // Forward strobe for time-of-day bytes and registers A/B.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_stb  <= 1'b0;
            fwd_idx  <= '0;
            fwd_data <= '0;
        end else begin
            fwd_stb  <= dat_wr && int'(idx_q) <= FWD_LAST;
            fwd_idx  <= idx_q[3:0];
            fwd_data <= bus_wdata;
        end
    end

    cmos_ctrl_regs u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_a    (dat_wr && int'(idx_q) == IDX_A),
        .wr_b    (dat_wr && int'(idx_q) == IDX_B),
        .wr_data (bus_wdata),
        .rd_c    (dat_rd && int'(idx_q) == IDX_C),
        .evt_set (evt_set),
        .uip_set (uip_set),
        .uip_clr (uip_clr),
        .reg_a   (reg_a),
        .reg_b   (reg_b),
        .reg_c   (reg_c),
        .reg_d   (reg_d),
        .irq     (irq)
    );

    assign ck_byte = mem[IDX_W'(CK_FIRST) + IDX_W'(ck_off)];

    cmos_cksum #(.LEN(CK_LEN)) u_ck (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (ck_start),
        .rd_byte (ck_byte),
        .rd_off  (ck_off),
        .busy    (cksum_busy),
        .sum     (ck_sum)
    );

    // Read mux: index port reads all ones, data port decodes the index.
    always_comb begin
        if (!bus_addr)                    bus_rdata = 8'hFF;
        else if (int'(idx_q) == IDX_A)    bus_rdata = reg_a;
        else if (int'(idx_q) == IDX_B)    bus_rdata = reg_b;
        else if (int'(idx_q) == IDX_C)    bus_rdata = reg_c;
        else if (int'(idx_q) == IDX_D)    bus_rdata = reg_d;
        else if (int'(idx_q) == CK_HIB)   bus_rdata = ck_sum[2*DATA_W-1:DATA_W];
        else if (int'(idx_q) == CK_LOB)   bus_rdata = ck_sum[DATA_W-1:0];
        else                              bus_rdata = mem[idx_q];
    end

    assign ctl_a = reg_a;
    assign ctl_b = reg_b;

    AST_INDEX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr) |=> idx_q == $past(bus_wdata[IDX_W-1:0])); // R2
    AST_FWD_ON_TOD: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && int'(idx_q) <= FWD_LAST) |=> fwd_stb); // R10
    AST_NO_BUS_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (!cksum_busy && !bd_wr) |=> !cksum_busy); // R9
endmodule

// File: tb/cmos_regfile_tb.sv
`timescale 1ns/1ps
module cmos_regfile_tb;
    logic clk = 0, rst_n = 0;
    logic bus_wr = 0, bus_rd = 0, bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic bd_wr = 0;
    logic [6:0] bd_idx = 0;
    logic [7:0] bd_wdata = 0, evt_set = 0;
    logic uip_set = 0, uip_clr = 0;
    logic irq, cksum_busy, fwd_stb;
    logic [7:0] ctl_a, ctl_b, fwd_data;
    logic [3:0] fwd_idx;

    int vectors = 0, miscompares = 0;
    bit done = 0;
    logic [7:0] model [128];

    always #4 clk = ~clk;

    cmos_regfile u_dut (.*);

    task automatic chk(input string req, input int got, input int exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic bwrite(input logic a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic bread(input logic a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic rd_at(input int i, output logic [7:0] d);
        bwrite(0, 8'(i)); bread(1, d);
    endtask

    task automatic wr_at(input int i, input logic [7:0] d);
        bwrite(0, 8'(i)); bwrite(1, d);
    endtask

    task automatic bdw(input int i, input logic [7:0] d);
        @(negedge clk); bd_wr = 1; bd_idx = 7'(i); bd_wdata = d;
        @(negedge clk); bd_wr = 0;
    endtask

    function automatic int model_sum();
        int s = 0;
        for (int k = 16; k <= 45; k++) s += model[k];
        return s & 16'hFFFF;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, hi, lo;
        int s;
        for (int k = 0; k < 128; k++) model[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd_at(10, d); chk("R1 A", d, 8'h26);
        rd_at(11, d); chk("R1 B", d, 8'h02);
        rd_at(12, d); chk("R1 C", d, 8'h00);
        rd_at(13, d); chk("R1 D", d, 8'h80);
        rd_at(46, d); chk("R1 cksum hi", d, 0);
        rd_at(47, d); chk("R1 cksum lo", d, 0);
        chk("R1 irq", irq, 0); chk("R1 busy", cksum_busy, 0);

        // R2 even read
        bread(0, d); chk("R2 even read", d, 8'hFF);
        bwrite(0, 8'hC5); bread(1, d); chk("R2 index low 7 bits (0x45)", d, 0);

        // R7/R9 sweep of plain store via bus
        for (int i = 0; i < 128; i++) begin
            if ((i >= 10 && i <= 13) || i == 46 || i == 47) continue;
            model[i] = 8'((i * 37 + 5) & 8'hFF);
            wr_at(i, model[i]);
        end
        for (int i = 0; i < 128; i++) begin
            if ((i >= 10 && i <= 13) || i == 46 || i == 47) continue;
            rd_at(i, d); chk($sformatf("R7 byte %0d", i), d, model[i]);
        end
        chk("R9 bus write no recompute", cksum_busy, 0);
        rd_at(47, d); chk("R9 cksum lo unchanged", d, 0);

        // R10 forward strobe
        bwrite(0, 8'd7); bwrite(1, 8'h31);
        chk("R10 stb", fwd_stb, 1); chk("R10 idx", fwd_idx, 7); chk("R10 data", fwd_data, 8'h31);
        model[7] = 8'h31;
        bwrite(0, 8'd20); bwrite(1, model[20]);
        chk("R10 no stb above 11", fwd_stb, 0);

        // R3 A bit 7 protected
        wr_at(10, 8'hFF); rd_at(10, d); chk("R3 A write 0xFF", d, 8'h7F);
        @(negedge clk); uip_set = 1; @(negedge clk); uip_set = 0;
        rd_at(10, d); chk("R11 uip_set", d, 8'hFF);
        wr_at(10, 8'h26); rd_at(10, d); chk("R3 A keeps bit7", d, 8'hA6);
        @(negedge clk); uip_set = 1; uip_clr = 1; @(negedge clk); uip_set = 0; uip_clr = 0;
        rd_at(10, d); chk("R11 clr wins", d, 8'h26);

        // R6 SET overrides uip_set
        bwrite(0, 8'd11);
        uip_set = 1; bwrite(1, 8'h82); uip_set = 0;
        rd_at(10, d); chk("R6 A bit7 cleared", d, 8'h26);
        rd_at(11, d); chk("R6 B value", d, 8'h82);
        wr_at(11, 8'h02);

        // R4 read-only bytes
        wr_at(13, 8'h00); rd_at(13, d); chk("R4 D", d, 8'h80);
        wr_at(12, 8'h55); rd_at(12, d); chk("R4 C", d, 8'h00);
        wr_at(46, 8'h77); rd_at(46, d); chk("R4 cksum hi", d, 0);

        // R5 event, read-clear
        @(negedge clk); evt_set = 8'h90; @(negedge clk); evt_set = 0;
        chk("R5 irq raised", irq, 1);
        @(negedge clk); evt_set = 8'h20; @(negedge clk); evt_set = 0;
        rd_at(12, d); chk("R5 C value", d, 8'hB0);
        chk("R5 irq dropped", irq, 0);
        rd_at(12, d); chk("R5 C cleared", d, 8'h00);

        // R8 checksum, varied pattern
        for (int i = 16; i <= 45; i++) begin
            model[i] = 8'((i * 13 + 200) & 8'hFF);
            bdw(i, model[i]);
        end
        chk("R8 busy after trigger", cksum_busy, 1);
        rd_at(47, d); chk("R8 old lo during busy", d, 0);
        repeat (30) @(negedge clk);
        chk("R8 busy ends", cksum_busy, 0);
        s = model_sum();
        rd_at(46, hi); rd_at(47, lo);
        chk("R8 sum varied", {hi, lo}, s);

        // R8 all-ones pattern, carry into high byte
        for (int i = 16; i <= 45; i++) begin model[i] = 8'hFF; bdw(i, 8'hFF); end
        rd_at(46, d); chk("R8 old hi during busy", d, s >> 8);
        repeat (32) @(negedge clk);
        rd_at(46, hi); rd_at(47, lo);
        chk("R8 sum all ones", {hi, lo}, 16'h1DE2);

        // R9 backdoor outside range; R7 backdoor ignored on protected
        bdw(80, 8'h5A);
        chk("R9 out-of-range no busy", cksum_busy, 0);
        rd_at(80, d); chk("R7 backdoor byte", d, 8'h5A);
        bdw(13, 8'h00); rd_at(13, d); chk("R7 backdoor D ignored", d, 8'h80);
        bdw(47, 8'h00); rd_at(47, d); chk("R7 backdoor cksum ignored", d, 8'hE2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule